// File: doc/BRIEF.md
# USB Controller Raw Interrupt Status Aggregator

This block assembles the eight-bit raw interrupt vector of a USB host/device serial interface engine. Each bit has its own rule. Three bits copy engine error flags directly. One bit is the OR of the buffer-status vector. The other four are sticky flags: transfer complete, start-of-frame sent, remote wakeup and connection change. Each sticky flag has its own clear trigger, taken from accesses on the register bus.

The sticky flags clear as side effects of bus traffic that is aimed at other registers. A write that sets a chosen bit of the engine status register clears the transfer-complete flag, the wakeup flag or the connection flag. A read of the frame-number register clears the start-of-frame flag. The three host-only flags stay at zero while the controller runs as a device. A mask input selects which raw bits drive the single active-high interrupt line.

The clear positions inside the status word and the two register addresses are parameters. All outputs are registered, and the block has a synchronous active-high reset.

Top module: `usb_irq_raw_agg`

## Requirements
- R1: In the cycle after reset is asserted, `raw_int` reads all zeros and `irq` reads 0.
- R2: `raw_int[7]`, `raw_int[6]` and `raw_int[5]` equal `rx_ovf`, `rx_tmo` and `seq_err` as sampled at the previous clock edge.
- R3: `raw_int[4]` is 1 exactly when any bit of `buf_status` was 1 at the previous clock edge, and it returns to 0 only once every bit of `buf_status` is 0.
- R4: A `xfer_done` pulse sets `raw_int[3]`. The bit stays set until a bus write to `STAT_ADDR` carries a 1 at `wdata[XFER_BIT]`. A write to that address with that bit at 0 leaves it unchanged.
- R5: In host mode a `sof_sent` pulse sets `raw_int[2]`. The bit clears on a bus read of `FRAME_ADDR`. A read of any other address leaves it unchanged.
- R6: In host mode a `wake_evt` pulse sets `raw_int[1]`. The bit clears on a bus write to `STAT_ADDR` that carries a 1 at `wdata[WAKE_BIT]`.
- R7: In host mode `raw_int[0]` sets when `line_speed` differs from its value at the previous clock edge. It clears on a bus write to `STAT_ADDR` whose field `wdata[SPD_LSB +: SPD_W]` is non-zero.
- R8: When a flag's set event and its clear trigger occur at the same edge, the flag ends up set.
- R9: When `host_mode` is 0, `raw_int[2:0]` is 0 from the next edge on, whatever events arrive.
- R10: `irq` equals the OR of `raw_int & int_mask`, taken one cycle after those values are present.
- R11: A bus write to any address other than `STAT_ADDR` clears no flag, even when it carries clear bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 = host operation, 0 = device operation |
| rx_ovf | input | 1 | Engine receive-overflow status level |
| rx_tmo | input | 1 | Engine receive-timeout status level |
| seq_err | input | 1 | Engine data-sequence error status level |
| buf_status | input | NBUF | Buffer-status vector |
| xfer_done | input | 1 | Pulse: transfer-complete status set |
| sof_sent | input | 1 | Pulse: host sent a start-of-frame |
| wake_evt | input | 1 | Pulse: device signalled remote wakeup |
| line_speed | input | SPD_W | Detected line speed code |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Register write data |
| int_mask | input | 8 | Per-bit interrupt enable |
| raw_int | output | 8 | Raw interrupt vector |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench builds the block with a 16-bit buffer-status vector, a 12-bit address bus, a 2-bit speed field and clear positions spread across the 32-bit status word. These settings let random traffic reach every clear path. They also give buffer vectors that go all-zero often, so bit 4 drops regularly.

Random bus traffic is mixed among the status address, the frame address and an unrelated address. This covers wrong-address clears and wrong-bit clears. It also covers set and clear events that land in the same cycle. Host mode is toggled several times during the run, so the device-mode hold on the low three bits is exercised in both directions.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int RAW_W  = 8;
  localparam int B_OVF  = 7;
  localparam int B_TMO  = 6;
  localparam int B_SEQ  = 5;
  localparam int B_BUF  = 4;
  localparam int N_FLAG = 4;
  localparam int F_XFER = 3;
  localparam int F_SOF  = 2;
  localparam int F_WAKE = 1;
  localparam int F_CONN = 0;

  typedef struct packed {
    logic xfer;
    logic frame;
    logic wake;
    logic conn;
  } clr_t;
endpackage

// File: rtl/usb_irq_bus_dec.sv
module usb_irq_bus_dec
  import usb_irq_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter logic [AW-1:0] STAT_ADDR  = 12'h050,
  parameter logic [AW-1:0] FRAME_ADDR = 12'h04C,
  parameter int XFER_BIT   = 19,
  parameter int WAKE_BIT   = 11,
  parameter int SPD_LSB    = 8,
  parameter int SPD_W      = 2
) (
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output clr_t          clr
);
  logic stat_wr;

  always_comb begin
    stat_wr    = bus_wr && (bus_addr == STAT_ADDR);
    clr.xfer   = stat_wr && bus_wdata[XFER_BIT];
    clr.wake   = stat_wr && bus_wdata[WAKE_BIT];
    clr.conn   = stat_wr && (bus_wdata[SPD_LSB +: SPD_W] != '0);
    clr.frame  = bus_rd && (bus_addr == FRAME_ADDR);
  end
endmodule

// File: rtl/usb_irq_flag.sv
module usb_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic hold_zero,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || hold_zero) q <= 1'b0;
    else if (set)         q <= 1'b1;
    else if (clr)         q <= 1'b0;
  end

  // R8: a set event beats a clear in the same cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set && clr && !hold_zero) |=> q);
  // R4: a clear with no set drops the flag
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);
  // R9: held flags stay low
  a_r9_hold_low: assert property (@(posedge clk) disable iff (rst)
    hold_zero |=> !q);
  // R4: without a clear the flag is sticky
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (q && !clr && !hold_zero) |=> q);
endmodule

// File: rtl/usb_irq_raw_agg.sv
module usb_irq_raw_agg
  import usb_irq_pkg::*;
#(
  parameter int NBUF      = 32,
  parameter int AW        = 12,
  parameter int DW        = 32,
  parameter logic [AW-1:0] STAT_ADDR  = 12'h050,
  parameter logic [AW-1:0] FRAME_ADDR = 12'h04C,
  parameter int XFER_BIT  = 19,
  parameter int WAKE_BIT  = 11,
  parameter int SPD_LSB   = 8,
  parameter int SPD_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_mode,
  input  logic             rx_ovf,
  input  logic             rx_tmo,
  input  logic             seq_err,
  input  logic [NBUF-1:0]  buf_status,
  input  logic             xfer_done,
  input  logic             sof_sent,
  input  logic             wake_evt,
  input  logic [SPD_W-1:0] line_speed,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [RAW_W-1:0] int_mask,
  output logic [RAW_W-1:0] raw_int,
  output logic             irq
);
  clr_t             clr;
  logic [SPD_W-1:0] spd_prev;
  logic             spd_chg;
  logic [2:0]       mir_q;
  logic             buf_q;
  logic             irq_q;
  logic [N_FLAG-1:0] f_set, f_clr, f_hold, f_q;

  usb_irq_bus_dec #(
    .AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR), .FRAME_ADDR(FRAME_ADDR),
    .XFER_BIT(XFER_BIT), .WAKE_BIT(WAKE_BIT), .SPD_LSB(SPD_LSB), .SPD_W(SPD_W)
  ) dec_i (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .clr(clr)
  );

  always_ff @(posedge clk) begin
    if (rst) spd_prev <= '0;
    else     spd_prev <= line_speed;
  end
  assign spd_chg = (line_speed != spd_prev);

  always_comb begin
    f_set[F_XFER]  = xfer_done;  f_clr[F_XFER] = clr.xfer;  f_hold[F_XFER] = 1'b0;
    f_set[F_SOF]   = sof_sent;   f_clr[F_SOF]  = clr.frame; f_hold[F_SOF]  = !host_mode;
    f_set[F_WAKE]  = wake_evt;   f_clr[F_WAKE] = clr.wake;  f_hold[F_WAKE] = !host_mode;
    f_set[F_CONN]  = spd_chg;    f_clr[F_CONN] = clr.conn;  f_hold[F_CONN] = !host_mode;
  end

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    usb_irq_flag flag_i (
      .clk(clk), .rst(rst), .set(f_set[i]), .clr(f_clr[i]),
      .hold_zero(f_hold[i]), .q(f_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mir_q <= '0;
      buf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      mir_q <= {rx_ovf, rx_tmo, seq_err};
      buf_q <= |buf_status;
      irq_q <= |(raw_int & int_mask);
    end
  end

  assign raw_int = {mir_q, buf_q, f_q};
  assign irq     = irq_q;

  // R2: mirrors follow the engine flags one cycle later
  a_r2_mirror: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> raw_int[B_OVF:B_SEQ] == $past({rx_ovf, rx_tmo, seq_err}));
  // R3: buffer summary drops only when the whole vector is clear
  a_r3_buf_zero: assert property (@(posedge clk) disable iff (rst)
    (buf_status == '0) |=> !raw_int[B_BUF]);
  a_r3_buf_any: assert property (@(posedge clk) disable iff (rst)
    (buf_status != '0) |=> raw_int[B_BUF]);
  // R10: interrupt line follows masked raw bits by one cycle
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(raw_int & int_mask)));
  // R11: a write elsewhere never clears the transfer flag
  a_r11_wrong_addr: assert property (@(posedge clk) disable iff (rst)
    (raw_int[F_XFER] && !bus_rd && bus_wr && bus_addr != STAT_ADDR) |=> raw_int[F_XFER]);
endmodule

// File: tb/usb_irq_raw_agg_tb.sv
module usb_irq_raw_agg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBUF = 16;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] STAT_A  = 12'h050;
  localparam logic [AW-1:0] FRAME_A = 12'h04C;
  localparam logic [AW-1:0] OTHER_A = 12'h010;
  localparam int XFER_BIT = 19;
  localparam int WAKE_BIT = 11;
  localparam int SPD_LSB = 8;
  localparam int SPD_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_mode = 1'b1;
  logic rx_ovf = 0, rx_tmo = 0, seq_err = 0;
  logic [NBUF-1:0] buf_status = '0;
  logic xfer_done = 0, sof_sent = 0, wake_evt = 0;
  logic [SPD_W-1:0] line_speed = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [7:0] int_mask = '0;
  logic [7:0] raw_int;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_raw_agg #(
    .NBUF(NBUF), .AW(AW), .DW(DW), .STAT_ADDR(STAT_A), .FRAME_ADDR(FRAME_A),
    .XFER_BIT(XFER_BIT), .WAKE_BIT(WAKE_BIT), .SPD_LSB(SPD_LSB), .SPD_W(SPD_W)
  ) dut_i (
    .clk(clk), .rst(rst), .host_mode(host_mode), .rx_ovf(rx_ovf), .rx_tmo(rx_tmo),
    .seq_err(seq_err), .buf_status(buf_status), .xfer_done(xfer_done),
    .sof_sent(sof_sent), .wake_evt(wake_evt), .line_speed(line_speed),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .int_mask(int_mask), .raw_int(raw_int), .irq(irq)
  );

  // Behavioural reference model, updated at each rising edge
  logic [7:0] m_raw = '0;
  logic       m_irq = 1'b0;
  logic [SPD_W-1:0] m_spd = '0;

  always @(posedge clk) begin
    bit swr, c_x, c_w, c_s, c_f;
    logic [7:0] n;
    if (rst) begin
      m_raw <= '0; m_irq <= 1'b0; m_spd <= '0;
    end else begin
      swr = bus_wr && (bus_addr == STAT_A);
      c_x = swr && bus_wdata[XFER_BIT];
      c_w = swr && bus_wdata[WAKE_BIT];
      c_s = swr && (bus_wdata[SPD_LSB +: SPD_W] != 0);
      c_f = bus_rd && (bus_addr == FRAME_A);
      n[7] = rx_ovf; n[6] = rx_tmo; n[5] = seq_err;
      n[4] = (buf_status != 0);
      n[3] = xfer_done ? 1'b1 : (c_x ? 1'b0 : m_raw[3]);
      if (host_mode) begin
        n[2] = sof_sent ? 1'b1 : (c_f ? 1'b0 : m_raw[2]);
        n[1] = wake_evt ? 1'b1 : (c_w ? 1'b0 : m_raw[1]);
        n[0] = (line_speed != m_spd) ? 1'b1 : (c_s ? 1'b0 : m_raw[0]);
      end else begin
        n[2:0] = 3'b000;
      end
      m_irq <= ((m_raw & int_mask) != 0);
      m_raw <= n;
      m_spd <= line_speed;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2", {29'd0, raw_int[7:5]}, {29'd0, m_raw[7:5]});
    chk("R3", {31'd0, raw_int[4]}, {31'd0, m_raw[4]});
    chk("R4", {31'd0, raw_int[3]}, {31'd0, m_raw[3]});
    chk("R5", {31'd0, raw_int[2]}, {31'd0, m_raw[2]});
    chk("R6", {31'd0, raw_int[1]}, {31'd0, m_raw[1]});
    chk("R7", {31'd0, raw_int[0]}, {31'd0, m_raw[0]});
    chk("R10", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic idle();
    xfer_done = 0; sof_sent = 0; wake_evt = 0;
    bus_wr = 0; bus_rd = 0; bus_addr = OTHER_A; bus_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {24'd0, raw_int}, 32'd0);
    chk("R1", {31'd0, irq}, 32'd0);
    rst = 0;
    int_mask = 8'hFF;

    // R8: transfer set and its clear in one cycle
    xfer_done = 1; bus_wr = 1; bus_addr = STAT_A; bus_wdata = 32'd1 << XFER_BIT;
    step(); idle();
    chk("R8", {31'd0, raw_int[3]}, 32'd1);
    // R11: clear bits written to another address do nothing
    bus_wr = 1; bus_addr = OTHER_A; bus_wdata = 32'hFFFF_FFFF;
    step(); idle();
    chk("R11", {31'd0, raw_int[3]}, 32'd1);
    // R4: write with clear bit low keeps flag, with bit high clears
    bus_wr = 1; bus_addr = STAT_A; bus_wdata = ~(32'd1 << XFER_BIT) & ~(32'd3 << SPD_LSB) & ~(32'd1 << WAKE_BIT);
    step(); idle();
    chk("R4", {31'd0, raw_int[3]}, 32'd1);
    bus_wr = 1; bus_addr = STAT_A; bus_wdata = 32'd1 << XFER_BIT;
    step(); idle();
    chk("R4", {31'd0, raw_int[3]}, 32'd0);
    // R5: read elsewhere keeps SOF flag, frame read clears
    sof_sent = 1; step(); idle();
    bus_rd = 1; bus_addr = OTHER_A; step(); idle();
    chk("R5", {31'd0, raw_int[2]}, 32'd1);
    bus_rd = 1; bus_addr = FRAME_A; step(); idle();
    chk("R5", {31'd0, raw_int[2]}, 32'd0);
    // R9: device mode holds host bits low despite events
    host_mode = 0; sof_sent = 1; wake_evt = 1; line_speed = 2'd2;
    step(); idle();
    chk("R9", {29'd0, raw_int[2:0]}, 32'd0);
    step();
    chk("R9", {29'd0, raw_int[2:0]}, 32'd0);
    host_mode = 1;
    step();

    // Random phase, compared with the model every cycle
    for (int c = 0; c < 4000; c++) begin
      rx_ovf  = ($urandom % 4) == 0;
      rx_tmo  = ($urandom % 4) == 0;
      seq_err = ($urandom % 4) == 0;
      buf_status = (($urandom % 3) == 0) ? '0 : NBUF'(1) << ($urandom % NBUF);
      xfer_done = ($urandom % 8) == 0;
      sof_sent  = ($urandom % 8) == 0;
      wake_evt  = ($urandom % 8) == 0;
      if (($urandom % 10) == 0) line_speed = SPD_W'($urandom);
      bus_wr = ($urandom % 3) == 0;
      bus_rd = ($urandom % 3) == 0;
      case ($urandom % 3)
        0: bus_addr = STAT_A;
        1: bus_addr = FRAME_A;
        default: bus_addr = OTHER_A;
      endcase
      bus_wdata = $urandom;
      if (($urandom % 16) == 0) int_mask = 8'($urandom);
      if ((c % 600) == 599) host_mode = ~host_mode;
      step();
    end
    idle();
    step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule